// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the software-visible face of one DMA channel. A host reaches it through a small request/response bus that accepts 32-bit and 64-bit little-endian accesses. Through this bus software builds a pending transfer descriptor: configuration, byte count, destination and source. It must take ownership of the channel before it may launch the transfer. Once launched, the block copies the pending descriptor into a read-only working copy. It then sends a one-cycle start pulse to a separate data-movement engine. That engine reports its progress and its final outcome back to this block.

The ownership handshake works through two bits of the control word. A claim bit must already be set before a run request is honoured. Claim cannot be released while a transfer is in flight. Taking ownership of an idle, unowned channel reloads the pending descriptor with defaults of 64-byte read and write transfer sizes. Completion and failure each raise a sticky status bit. Each status bit drives its own registered, level-sensitive interrupt line when its enable bit is set. Software clears an interrupt by writing its status bit to zero.

The request side is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows, and it appears at the next edge. A response stays on `rsp_valid`/`rsp_rdata` until `rsp_ready` takes it. While a response is held and not being taken, `req_ready` is low, so nothing else is accepted. The engine-side pins are plain pulses and levels with no handshake.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0. The pending config reads 0x6600_0000. The pending byte count, destination and source read 0. Both interrupt lines are low and no response is pending.
- R2: The pending byte count, destination and source are 64-bit registers at offsets 0x008, 0x010 and 0x018. An 8-byte access at the base offset moves the whole register. A 4-byte access moves bits 31:0 at the base offset and bits 63:32 at base+4. A 4-byte write changes only its own half. Read data from a 4-byte access sits in bits 31:0 of `rsp_rdata`, with the upper bits zero.
- R3: A control write (4 bytes at 0x000) that sets claim (bit 0) on an unclaimed channel reloads the pending descriptor. The pending config (4 bytes at 0x004) becomes read size 6 in bits 31:28 and write size 6 in bits 27:24, with all other bits zero. The pending byte count, destination and source become 0.
- R4: While run (bit 1) reads 1, a control write cannot clear claim or run. It updates only done-enable (bit 14), error-enable (bit 15), done (bit 30) and error (bit 31).
- R5: A control write that requests run has no effect on run in two cases: when the channel was unclaimed before the write, and when the written claim bit is 0. In both cases run reads 0 afterwards and no start pulse occurs.
- R6: A control write that requests run on a claimed channel, keeps claim set, and passes the R7 checks does four things. It raises `eng_start` for exactly the one cycle after the accepting edge. It copies the pending descriptor into the working copy. It clears done and error. It leaves run at 1.
- R7: A run request on a claimed channel with a pending byte count of 0 sets done and clears run, with no start pulse. A run request whose write size (config bits 27:24) differs from its read size (bits 31:28) sets error and clears run, with no start pulse.
- R8: While run is 1, each `prog_valid` cycle adds `prog_len` to the working destination and source and subtracts it from the working byte count. `eng_err` clears run and sets error. `eng_done` clears run and sets done. If the working config has its repeat bit (bit 2) set, `eng_done` also restores the working byte count, destination and source to their values at launch. Engine inputs are ignored while run is 0.
- R9: The working copy is readable at 0x104 (config, 4 bytes) and at 0x108, 0x110 and 0x118 (byte count, destination, source, accessed as in R2). Writes to it have no effect.
- R10: `irq_done` equals done-enable AND done, and `irq_err` equals error-enable AND error, each as held in the control word one cycle earlier.
- R11: An access with a size code other than 2 (4 bytes) or 3 (8 bytes), an access to an unmapped or misaligned offset, and an access whose `req_chan` differs from `CHAN_ID` all read back 0 and change nothing. Each still returns one response.
- R12: A response that is not taken keeps `rsp_valid` and `rsp_rdata` unchanged, and `req_ready` stays low until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | CHAN_W | Channel index of the access |
| req_addr | input | 12 | Byte offset inside the channel window |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data (0 for writes) |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_cfg | output | 32 | Working config |
| eng_bytes | output | 64 | Working byte count |
| eng_dst | output | 64 | Working destination address |
| eng_src | output | 64 | Working source address |
| prog_valid | input | 1 | Engine moved `prog_len` bytes this cycle |
| prog_len | input | LEN_W | Bytes moved |
| eng_done | input | 1 | Engine finished the transfer |
| eng_err | input | 1 | Engine failed the transfer |
| irq_done | output | 1 | Completion interrupt level |
| irq_err | output | 1 | Failure interrupt level |

## Verification
The assertions assume the engine behaves: it raises `eng_done`, `eng_err` and `prog_valid` only while a transfer is active, never raises the two outcome pulses together, and never reports progress in the same cycle as an outcome. They also assume that at most one bus access is accepted per cycle. The bench keeps to these rules by driving engine events only when its own model shows run at 1, and by issuing each engine event alone in its own cycle. Random ownership, configuration and byte-count writes are biased so that the zero-length, size-mismatch and unclaimed-run cases all occur.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int ADDR_W = 12;
  localparam int REG_W  = 64;
  localparam int HALF_W = 32;

  // control word bit positions
  localparam int CB_CLAIM   = 0;
  localparam int CB_RUN     = 1;
  localparam int CB_DONE_IE = 14;
  localparam int CB_ERR_IE  = 15;
  localparam int CB_DONE    = 30;
  localparam int CB_ERR     = 31;

  // config word fields
  localparam int CFG_REPEAT  = 2;
  localparam int CFG_WSZ_LSB = 24;
  localparam int CFG_RSZ_LSB = 28;
  localparam int CFG_SZ_W    = 4;
  localparam logic [CFG_SZ_W-1:0] CFG_SZ_DEF = 4'd6;
  localparam logic [HALF_W-1:0] CFG_DEFAULT =
    (HALF_W'(CFG_SZ_DEF) << CFG_RSZ_LSB) | (HALF_W'(CFG_SZ_DEF) << CFG_WSZ_LSB);

  // size codes (log2 bytes)
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  // offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL_PAIR = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_NBYTES    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_NDST      = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_NSRC      = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_XCFG_PAIR = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_XBYTES    = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_XDST      = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_XSRC      = 12'h118;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_NCFG, RG_NBYTES, RG_NDST, RG_NSRC,
    RG_XCFG, RG_XBYTES, RG_XDST, RG_XSRC
  } reg_id_e;

  typedef enum logic [1:0] {PART_LO, PART_HI, PART_FULL} part_e;

  typedef struct packed {
    reg_id_e id;
    part_e   part;
  } acc_t;

  typedef struct packed {
    logic err;
    logic done;
    logic err_ie;
    logic done_ie;
    logic run;
    logic claim;
  } ctrl_t;

  function automatic reg_id_e wide_at(input logic [ADDR_W-1:0] base);
    reg_id_e r;
    case (base)
      OFS_NBYTES: r = RG_NBYTES;
      OFS_NDST:   r = RG_NDST;
      OFS_NSRC:   r = RG_NSRC;
      OFS_XBYTES: r = RG_XBYTES;
      OFS_XDST:   r = RG_XDST;
      OFS_XSRC:   r = RG_XSRC;
      default:    r = RG_NONE;
    endcase
    return r;
  endfunction

  function automatic acc_t decode_acc(input logic [ADDR_W-1:0] a,
                                      input logic [1:0] sz);
    acc_t r;
    logic [ADDR_W-1:0] base;
    reg_id_e w;
    base   = {a[ADDR_W-1:3], 3'b000};
    w      = wide_at(base);
    r.id   = RG_NONE;
    r.part = PART_LO;
    if (sz == SZ_WORD && a[1:0] == 2'b00) begin
      if (base == OFS_CTRL_PAIR)      r.id = a[2] ? RG_NCFG : RG_CTRL;
      else if (base == OFS_XCFG_PAIR) r.id = a[2] ? RG_XCFG : RG_NONE;
      else if (w != RG_NONE) begin
        r.id   = w;
        r.part = a[2] ? PART_HI : PART_LO;
      end
    end else if (sz == SZ_DWORD && a[2:0] == 3'b000 && w != RG_NONE) begin
      r.id   = w;
      r.part = PART_FULL;
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] merge_part(input logic [REG_W-1:0] old,
                                                  input part_e p,
                                                  input logic [REG_W-1:0] wd);
    case (p)
      PART_LO: return {old[REG_W-1:HALF_W], wd[HALF_W-1:0]};
      PART_HI: return {wd[HALF_W-1:0], old[HALF_W-1:0]};
      default: return wd;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pick_part(input logic [REG_W-1:0] v,
                                                 input part_e p);
    case (p)
      PART_LO: return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      PART_HI: return {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
      default: return v;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] ctrl_word(input ctrl_t c);
    logic [HALF_W-1:0] w;
    w             = '0;
    w[CB_CLAIM]   = c.claim;
    w[CB_RUN]     = c.run;
    w[CB_DONE_IE] = c.done_ie;
    w[CB_ERR_IE]  = c.err_ie;
    w[CB_DONE]    = c.done;
    w[CB_ERR]     = c.err;
    return w;
  endfunction

endpackage

// File: rtl/dma_bus_port.sv
module dma_bus_port
  import dma_chan_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_W-1:0]  rsp_rdata,
  output acc_t              acc,
  output logic              wr_en,
  input  logic [REG_W-1:0]  rd_value
);

  localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(CHAN_ID);

  logic fire;
  logic hit;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign hit       = fire && (req_chan == MY_CHAN);

  always_comb begin
    acc = '{id: RG_NONE, part: PART_LO};
    if (hit) acc = decode_acc(req_addr, req_size);
  end

  assign wr_en = hit && req_write && (acc.id != RG_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : pick_part(rd_value, acc.part);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R12

endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import dma_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wr_val,
  input  logic  bytes_zero,
  input  logic  size_mismatch,
  input  logic  eng_done,
  input  logic  eng_err,
  output ctrl_t ctrl_q,
  output logic  claim_reset,
  output logic  launch,
  output logic  eng_start
);

  ctrl_t nxt;

  always_comb begin
    nxt         = ctrl_q;
    claim_reset = 1'b0;
    launch      = 1'b0;
    if (wr_ctrl) begin
      if (ctrl_q.run) begin
        // in flight: ownership and run are locked
        nxt.done_ie = wr_val.done_ie;
        nxt.err_ie  = wr_val.err_ie;
        nxt.done    = wr_val.done;
        nxt.err     = wr_val.err;
      end else begin
        nxt = wr_val;
        if (!ctrl_q.claim && wr_val.claim) claim_reset = 1'b1;
        if (!ctrl_q.claim || !wr_val.claim) begin
          nxt.run = 1'b0;
        end else if (wr_val.run) begin
          if (bytes_zero) begin
            nxt.run  = 1'b0;
            nxt.done = 1'b1;
            nxt.err  = 1'b0;
          end else if (size_mismatch) begin
            nxt.run  = 1'b0;
            nxt.done = 1'b0;
            nxt.err  = 1'b1;
          end else begin
            nxt.done = 1'b0;
            nxt.err  = 1'b0;
            launch   = 1'b1;
          end
        end
      end
    end
    if (ctrl_q.run && (eng_done || eng_err)) begin
      nxt.run = 1'b0;
      if (eng_err) nxt.err  = 1'b1;
      else         nxt.done = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      eng_start <= 1'b0;
    end else begin
      ctrl_q    <= nxt;
      eng_start <= launch;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6
  AST_START_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ctrl_q.claim && ctrl_q.run); // R5
  AST_CLAIM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run |=> ctrl_q.claim); // R4
  AST_END_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run && (eng_done || eng_err) |=> !ctrl_q.run); // R8

endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chan_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  acc_t              acc,
  input  logic [REG_W-1:0]  wdata,
  input  logic              claim_reset,
  input  logic              launch,
  input  logic              prog,
  input  logic [LEN_W-1:0]  prog_len,
  input  logic              reload,
  output logic [HALF_W-1:0] ncfg_q,
  output logic [HALF_W-1:0] xcfg_q,
  output logic [REG_W-1:0]  n_q [3],
  output logic [REG_W-1:0]  x_q [3]
);

  logic [REG_W-1:0] snap_q [3];
  logic [REG_W-1:0] step;

  assign step = REG_W'(prog_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncfg_q <= CFG_DEFAULT;
      xcfg_q <= '0;
    end else begin
      if (claim_reset)                    ncfg_q <= CFG_DEFAULT;
      else if (wr_en && acc.id == RG_NCFG) ncfg_q <= wdata[HALF_W-1:0];
      if (launch) xcfg_q <= ncfg_q;
    end
  end

  AST_CLAIM_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    claim_reset |=> ncfg_q == CFG_DEFAULT && n_q[0] == '0); // R3

  for (genvar g = 0; g < 3; g++) begin : g_slot
    localparam reg_id_e MY_ID = (g == 0) ? RG_NBYTES : (g == 1) ? RG_NDST : RG_NSRC;
    localparam bit      DOWN  = (g == 0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_q[g]    <= '0;
        x_q[g]    <= '0;
        snap_q[g] <= '0;
      end else begin
        if (claim_reset)                   n_q[g] <= '0;
        else if (wr_en && acc.id == MY_ID) n_q[g] <= merge_part(n_q[g], acc.part, wdata);
        if (launch) begin
          x_q[g]    <= n_q[g];
          snap_q[g] <= n_q[g];
        end else if (prog) begin
          x_q[g] <= DOWN ? x_q[g] - step : x_q[g] + step;
        end else if (reload) begin
          x_q[g] <= snap_q[g];
        end
      end
    end

    AST_EXEC_RO: assert property (@(posedge clk) disable iff (!rst_n)
      !launch && !prog && !reload |=> $stable(x_q[g])); // R9
  end

endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] enable,
  input  logic [N_LINES-1:0] status,
  output logic [N_LINES-1:0] irq
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[g] <= 1'b0;
      else        irq[g] <= enable[g] && status[g];
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 0,
  parameter int LEN_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              eng_start,
  output logic [31:0]       eng_cfg,
  output logic [63:0]       eng_bytes,
  output logic [63:0]       eng_dst,
  output logic [63:0]       eng_src,
  input  logic              prog_valid,
  input  logic [LEN_W-1:0]  prog_len,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              irq_done,
  output logic              irq_err
);

  acc_t              acc;
  logic              wr_en;
  logic [REG_W-1:0]  rd_value;
  ctrl_t             ctrl_q;
  ctrl_t             wr_val;
  logic              claim_reset;
  logic              launch;
  logic [HALF_W-1:0] ncfg_q;
  logic [HALF_W-1:0] xcfg_q;
  logic [REG_W-1:0]  n_q [3];
  logic [REG_W-1:0]  x_q [3];
  logic              prog;
  logic              reload;
  logic [1:0]        irq_v;

  dma_bus_port #(.CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) u_port (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_chan, .req_addr,
    .req_size, .rsp_valid, .rsp_ready, .rsp_rdata, .acc, .wr_en, .rd_value
  );

  assign wr_val = '{err: req_wdata[CB_ERR], done: req_wdata[CB_DONE],
                    err_ie: req_wdata[CB_ERR_IE], done_ie: req_wdata[CB_DONE_IE],
                    run: req_wdata[CB_RUN], claim: req_wdata[CB_CLAIM]};

  dma_ctrl_fsm u_fsm (
    .clk, .rst_n,
    .wr_ctrl       (wr_en && acc.id == RG_CTRL),
    .wr_val        (wr_val),
    .bytes_zero    (n_q[0] == '0),
    .size_mismatch (ncfg_q[CFG_WSZ_LSB +: CFG_SZ_W] != ncfg_q[CFG_RSZ_LSB +: CFG_SZ_W]),
    .eng_done, .eng_err, .ctrl_q, .claim_reset, .launch, .eng_start
  );

  assign prog   = ctrl_q.run && prog_valid;
  assign reload = ctrl_q.run && eng_done && !eng_err && xcfg_q[CFG_REPEAT];

  dma_desc_regs #(.LEN_W(LEN_W)) u_desc (
    .clk, .rst_n, .wr_en, .acc, .wdata(req_wdata), .claim_reset, .launch,
    .prog, .prog_len, .reload, .ncfg_q, .xcfg_q, .n_q, .x_q
  );

  always_comb begin
    case (acc.id)
      RG_CTRL:   rd_value = {{HALF_W{1'b0}}, ctrl_word(ctrl_q)};
      RG_NCFG:   rd_value = {{HALF_W{1'b0}}, ncfg_q};
      RG_NBYTES: rd_value = n_q[0];
      RG_NDST:   rd_value = n_q[1];
      RG_NSRC:   rd_value = n_q[2];
      RG_XCFG:   rd_value = {{HALF_W{1'b0}}, xcfg_q};
      RG_XBYTES: rd_value = x_q[0];
      RG_XDST:   rd_value = x_q[1];
      RG_XSRC:   rd_value = x_q[2];
      default:   rd_value = '0;
    endcase
  end

  dma_irq_out #(.N_LINES(2)) u_irq (
    .clk, .rst_n,
    .enable ({ctrl_q.err_ie, ctrl_q.done_ie}),
    .status ({ctrl_q.err, ctrl_q.done}),
    .irq    (irq_v)
  );

  assign irq_done  = irq_v[0];
  assign irq_err   = irq_v[1];
  assign eng_cfg   = xcfg_q;
  assign eng_bytes = x_q[0];
  assign eng_dst   = x_q[1];
  assign eng_src   = x_q[2];

  AST_NO_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_bytes != '0); // R7
  AST_SIZES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_cfg[CFG_WSZ_LSB +: CFG_SZ_W] == eng_cfg[CFG_RSZ_LSB +: CFG_SZ_W]); // R7

endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;

  localparam int CHAN_W = 3;
  localparam int CHAN_ID = 2;
  localparam int LEN_W = 7;
  localparam logic [31:0] DEF_CFG = 32'h6600_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [CHAN_W-1:0] req_chan = CHAN_ID[CHAN_W-1:0];
  logic [11:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic prog_valid = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [LEN_W-1:0] prog_len = '0;
  logic req_ready, rsp_valid, eng_start, irq_done, irq_err;
  logic [63:0] rsp_rdata, eng_bytes, eng_dst, eng_src;
  logic [31:0] eng_cfg;

  always #4 clk = ~clk;

  dma_chan_regs #(.CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID), .LEN_W(LEN_W)) u_dma_chan_regs (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_chan, .req_addr,
    .req_size, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .eng_start,
    .eng_cfg, .eng_bytes, .eng_dst, .eng_src, .prog_valid, .prog_len,
    .eng_done, .eng_err, .irq_done, .irq_err
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench model
  logic m_claim, m_run, m_die, m_eie, m_done, m_err;
  logic [31:0] m_ncfg, m_xcfg;
  logic [63:0] m_n [3];
  logic [63:0] m_x [3];
  logic [63:0] m_s [3];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_ctrl();
    logic [31:0] w = '0;
    w[0] = m_claim; w[1] = m_run; w[14] = m_die; w[15] = m_eie; w[30] = m_done; w[31] = m_err;
    return w;
  endfunction

  function automatic int wide_idx(input logic [11:0] base, output bit exec);
    exec = base[8];
    case (base[7:0])
      8'h08: return 0;
      8'h10: return 1;
      8'h18: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [63:0] m_read(input logic [CHAN_W-1:0] ch, input logic [11:0] a, input logic [1:0] sz);
    bit ex; int i; logic [63:0] v;
    if (ch != CHAN_ID[CHAN_W-1:0]) return 0;
    if (a[11:9] != 0 || a[7:5] != 0) return 0;
    i = wide_idx({a[11:3], 3'b000}, ex);
    if (sz == 2'd2 && a[1:0] == 0) begin
      if (a == 12'h000) return {32'h0, m_ctrl()};
      if (a == 12'h004) return {32'h0, m_ncfg};
      if (a == 12'h104) return {32'h0, m_xcfg};
      if (i < 0) return 0;
      v = ex ? m_x[i] : m_n[i];
      return a[2] ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
    end
    if (sz == 2'd3 && a[2:0] == 0 && i >= 0) return ex ? m_x[i] : m_n[i];
    return 0;
  endfunction

  // returns 1 when a start pulse is expected
  function automatic bit m_write(input logic [CHAN_W-1:0] ch, input logic [11:0] a, input logic [1:0] sz, input logic [63:0] w);
    bit ex; int i;
    if (ch != CHAN_ID[CHAN_W-1:0]) return 0;
    if (sz == 2'd2 && a == 12'h000) begin
      if (m_run) begin
        m_die = w[14]; m_eie = w[15]; m_done = w[30]; m_err = w[31];
        return 0;
      end
      if (!m_claim && w[0]) begin
        m_ncfg = DEF_CFG;
        for (int k = 0; k < 3; k++) m_n[k] = 0;
      end
      m_die = w[14]; m_eie = w[15]; m_done = w[30]; m_err = w[31];
      if (!m_claim || !w[0]) begin m_claim = w[0]; m_run = 1'b0; return 0; end
      m_claim = 1'b1;
      if (!w[1]) begin m_run = 1'b0; return 0; end
      if (m_n[0] == 0) begin m_run = 0; m_done = 1; m_err = 0; return 0; end
      if (m_ncfg[27:24] != m_ncfg[31:28]) begin m_run = 0; m_done = 0; m_err = 1; return 0; end
      m_run = 1; m_done = 0; m_err = 0; m_xcfg = m_ncfg;
      for (int k = 0; k < 3; k++) begin m_x[k] = m_n[k]; m_s[k] = m_n[k]; end
      return 1;
    end
    if (a[11:9] != 0 || a[7:5] != 0 || a[8]) return 0;
    if (sz == 2'd2 && a == 12'h004) begin m_ncfg = w[31:0]; return 0; end
    i = wide_idx({a[11:3], 3'b000}, ex);
    if (i < 0) return 0;
    if (sz == 2'd2 && a[1:0] == 0) begin
      if (a[2]) m_n[i][63:32] = w[31:0]; else m_n[i][31:0] = w[31:0];
    end else if (sz == 2'd3 && a[2:0] == 0) m_n[i] = w;
    return 0;
  endfunction

  task automatic bus(input bit wr, input logic [CHAN_W-1:0] ch, input logic [11:0] a,
                     input logic [1:0] sz, input logic [63:0] w, output logic [63:0] rd);
    req_valid = 1'b1; req_write = wr; req_chan = ch; req_addr = a; req_size = sz; req_wdata = w;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    chk(rsp_valid === 1'b1, "R12 response", {63'h0, rsp_valid}, 64'h1);
  endtask

  task automatic op_wr(input logic [CHAN_W-1:0] ch, input logic [11:0] a, input logic [1:0] sz, input logic [63:0] w);
    logic [63:0] rd; bit st;
    st = m_write(ch, a, sz, w);
    bus(1'b1, ch, a, sz, w, rd);
    chk(eng_start === st, "R6 start pulse", {63'h0, eng_start}, {63'h0, st});
  endtask

  task automatic op_rd(input logic [CHAN_W-1:0] ch, input logic [11:0] a, input logic [1:0] sz,
                       input string req, output logic [63:0] rd);
    logic [63:0] exp;
    exp = m_read(ch, a, sz);
    bus(1'b0, ch, a, sz, 64'h0, rd);
    chk(rd === exp, req, rd, exp);
  endtask

  task automatic op_eng(input bit pv, input int len, input bit d, input bit e);
    if (m_run) begin
      if (pv) begin
        m_x[0] -= 64'(len); m_x[1] += 64'(len); m_x[2] += 64'(len);
      end else if (d || e) begin
        m_run = 1'b0;
        if (e) m_err = 1'b1; else m_done = 1'b1;
        if (!e && m_xcfg[2]) for (int k = 0; k < 3; k++) m_x[k] = m_s[k];
      end
    end
    prog_valid = pv; prog_len = LEN_W'(len); eng_done = d; eng_err = e;
    @(posedge clk); @(negedge clk);
    prog_valid = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic chk_irq();
    @(negedge clk);
    chk(irq_done === (m_die & m_done), "R10 irq_done", {63'h0, irq_done}, {63'h0, m_die & m_done});
    chk(irq_err === (m_eie & m_err), "R10 irq_err", {63'h0, irq_err}, {63'h0, m_eie & m_err});
  endtask

  function automatic logic [11:0] rnd_addr();
    case ($urandom % 17)
      0: return 12'h000; 1: return 12'h004; 2: return 12'h008; 3: return 12'h00C;
      4: return 12'h010; 5: return 12'h014; 6: return 12'h018; 7: return 12'h01C;
      8: return 12'h104; 9: return 12'h108; 10: return 12'h10C; 11: return 12'h110;
      12: return 12'h114; 13: return 12'h118; 14: return 12'h11C; 15: return 12'h020;
      default: return 12'h00A;
    endcase
  endfunction

  localparam logic [CHAN_W-1:0] ME = CHAN_ID[CHAN_W-1:0];

  initial begin
    logic [63:0] rd, held;
    int unsigned sd;
    m_claim = 0; m_run = 0; m_die = 0; m_eie = 0; m_done = 0; m_err = 0;
    m_ncfg = DEF_CFG; m_xcfg = 0;
    for (int k = 0; k < 3; k++) begin m_n[k] = 0; m_x[k] = 0; m_s[k] = 0; end
    sd = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rsp_valid === 1'b0, "R1 no response", {63'h0, rsp_valid}, 64'h0);
    chk(irq_done === 1'b0 && irq_err === 1'b0, "R1 irq low", {62'h0, irq_err, irq_done}, 64'h0);
    op_rd(ME, 12'h000, 2'd2, "R1 ctrl", rd);
    op_rd(ME, 12'h004, 2'd2, "R1 config", rd);
    chk(rd === 64'h6600_0000, "R1 config literal", rd, 64'h6600_0000);
    op_rd(ME, 12'h010, 2'd3, "R1 dst", rd);

    // R2 halves
    op_wr(ME, 12'h010, 2'd3, 64'h1111_2222_3333_4444);
    op_wr(ME, 12'h014, 2'd2, 64'hFFFF_FFFF_ABCD_0123);
    op_rd(ME, 12'h010, 2'd3, "R2 full", rd);
    chk(rd === 64'hABCD_0123_3333_4444, "R2 half merge", rd, 64'hABCD_0123_3333_4444);
    op_rd(ME, 12'h014, 2'd2, "R2 hi half", rd);
    op_rd(ME, 12'h010, 2'd2, "R2 lo half", rd);

    // R9 exec read-only
    op_wr(ME, 12'h108, 2'd3, 64'hDEAD);
    op_wr(ME, 12'h104, 2'd2, 64'hBEEF);
    op_wr(ME, 12'h11C, 2'd2, 64'h77);
    op_rd(ME, 12'h108, 2'd3, "R9 exec bytes", rd);
    chk(rd === 64'h0, "R9 exec unchanged", rd, 64'h0);
    op_rd(ME, 12'h104, 2'd2, "R9 exec cfg", rd);

    // R11 bad size, unmapped, other channel
    op_wr(ME, 12'h008, 2'd1, 64'h55);
    op_wr(ME, 12'h008, 2'd0, 64'h55);
    op_wr(ME ^ 3'd1, 12'h018, 2'd3, 64'h99);
    op_rd(ME, 12'h008, 2'd3, "R11 size ignored", rd);
    op_rd(ME, 12'h018, 2'd3, "R11 chan ignored", rd);
    op_rd(ME ^ 3'd1, 12'h004, 2'd2, "R11 other chan reads 0", rd);
    op_rd(ME, 12'h020, 2'd3, "R11 unmapped", rd);
    op_rd(ME, 12'h00A, 2'd2, "R11 misaligned", rd);

    // R5 run while unclaimed
    op_wr(ME, 12'h008, 2'd3, 64'h40);
    op_wr(ME, 12'h000, 2'd2, 64'h3);
    op_rd(ME, 12'h000, 2'd2, "R5 unclaimed run", rd);
    chk(rd[1] === 1'b0, "R5 run cleared", rd, 64'h1);

    // R3 claim reset of descriptor (set above)
    op_rd(ME, 12'h008, 2'd3, "R3 bytes reset", rd);
    op_rd(ME, 12'h004, 2'd2, "R3 config default", rd);
    op_rd(ME, 12'h010, 2'd3, "R3 dst reset", rd);
    chk(rd === 64'h0, "R3 dst literal", rd, 64'h0);

    // R5 claim dropped with run
    op_wr(ME, 12'h008, 2'd3, 64'h40);
    op_wr(ME, 12'h000, 2'd2, 64'h2);
    op_rd(ME, 12'h000, 2'd2, "R5 release with run", rd);

    // R6 launch with repeat
    op_wr(ME, 12'h000, 2'd2, 64'h1);
    op_wr(ME, 12'h008, 2'd3, 64'h100);
    op_wr(ME, 12'h010, 2'd3, 64'h8000);
    op_wr(ME, 12'h018, 2'd3, 64'h4000);
    op_wr(ME, 12'h004, 2'd2, 64'h6600_0004);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_4003);
    chk(eng_bytes === 64'h100 && eng_dst === 64'h8000, "R6 exec loaded", eng_dst, 64'h8000);
    @(negedge clk);
    chk(eng_start === 1'b0, "R6 single pulse", {63'h0, eng_start}, 64'h0);
    op_rd(ME, 12'h110, 2'd3, "R6 exec dst", rd);

    // R4 locked while running
    op_wr(ME, 12'h000, 2'd2, 64'h0);
    op_rd(ME, 12'h000, 2'd2, "R4 claim held", rd);
    chk(rd === 64'h3, "R4 literal", rd, 64'h3);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_4000);

    // R8 progress and repeat reload
    op_eng(1'b1, 64, 1'b0, 1'b0);
    op_rd(ME, 12'h108, 2'd3, "R8 bytes decrement", rd);
    chk(rd === 64'hC0, "R8 literal", rd, 64'hC0);
    op_rd(ME, 12'h118, 2'd3, "R8 src advance", rd);
    op_eng(1'b0, 0, 1'b1, 1'b0);
    op_rd(ME, 12'h108, 2'd3, "R8 repeat reload", rd);
    op_rd(ME, 12'h000, 2'd2, "R8 done set", rd);
    chk_irq();
    chk(irq_done === 1'b1, "R10 done irq raised", {63'h0, irq_done}, 64'h1);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_4001);
    chk_irq();

    // R7 zero length and size mismatch
    op_wr(ME, 12'h008, 2'd3, 64'h0);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_C003);
    op_rd(ME, 12'h000, 2'd2, "R7 zero length done", rd);
    op_wr(ME, 12'h008, 2'd3, 64'h10);
    op_wr(ME, 12'h004, 2'd2, 64'h6500_0000);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_C003);
    op_rd(ME, 12'h000, 2'd2, "R7 size mismatch error", rd);
    chk(rd[31] === 1'b1, "R7 error bit", rd, 64'h8000_0000);
    chk_irq();

    // R8 engine error
    op_wr(ME, 12'h004, 2'd2, 64'h6600_0000);
    op_wr(ME, 12'h000, 2'd2, 64'h0000_8003);
    op_eng(1'b0, 0, 1'b0, 1'b1);
    op_rd(ME, 12'h000, 2'd2, "R8 engine error", rd);
    chk_irq();

    // R12 back-pressure
    rsp_ready = 1'b0;
    op_rd(ME, 12'h004, 2'd2, "R12 held read", held);
    chk(req_ready === 1'b0, "R12 req_ready low", {63'h0, req_ready}, 64'h0);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_rdata === held, "R12 data held", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 taken", {63'h0, rsp_valid}, 64'h0);

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int kind;
      logic [63:0] w;
      logic [CHAN_W-1:0] ch;
      kind = $urandom % 10;
      ch = ($urandom % 8 == 0) ? ME ^ 3'd4 : ME;
      if (m_run && kind < 3) begin
        if ($urandom % 3 != 0) op_eng(1'b1, $urandom_range(1, 64), 1'b0, 1'b0);
        else op_eng(1'b0, 0, ($urandom % 2) == 1, 1'b0) ;
        if (!m_run && m_done == 0 && m_err == 0) ;
      end else if (m_run && kind == 3) begin
        op_eng(1'b0, 0, 1'b0, 1'b1);
      end else if (kind < 6) begin
        w = '0;
        w[0] = ($urandom % 4) != 0; w[1] = ($urandom % 2) == 1;
        w[14] = $urandom % 2; w[15] = $urandom % 2;
        w[30] = $urandom % 2; w[31] = $urandom % 2;
        w[13:2] = 12'($urandom);
        op_wr(ch, 12'h000, 2'd2, w);
      end else if (kind < 8) begin
        logic [11:0] a;
        a = rnd_addr();
        w = {$urandom, $urandom};
        if (a == 12'h004) begin
          w[31:28] = 4'(5 + $urandom % 3); w[27:24] = 4'(5 + $urandom % 3);
        end
        if (($urandom % 4) == 0) w = 0;
        if (a == 12'h000) a = 12'h008;
        op_wr(ch, a, 2'($urandom % 4 == 0 ? $urandom % 4 : 2 + $urandom % 2), w);
      end else begin
        op_rd(ch, rnd_addr(), 2'(2 + $urandom % 2), "R2 R9 R11 random read", rd);
      end
      chk_irq();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule